// File: doc/BRIEF.md
# I2C Master Byte Buffers with Threshold Events

This block holds the two byte queues that sit between the register interface of an I2C master and its bit-level shift engine. Software pushes outgoing bytes by writing the data register and pops incoming bytes by reading it. The shift engine takes outgoing bytes and deposits received bytes through single-cycle handshakes. A configuration word sets a separate threshold for each direction and can flush either queue. A status word reports both fill levels and the queue size code.

The block compares the fill levels with the thresholds and with the number of bytes the software still has to move in the current transfer. From this it raises one-cycle event pulses for an interrupt unit. A ready event means a whole threshold's worth of bytes or free slots is available. A drain event means the tail of the transfer is shorter than the threshold and can now be handled in one go. For the receive drain case, software takes the exact byte count from the status word. Two further pulses flag a transmit underflow and a receive overrun. After firing, each ready or drain event stays quiet until software has moved data in its direction or flushed that queue.

The queue depth is 8 << SIZE_CODE, and the remaining-count width is CNT_W.

Top module: `i2c_thresh_buf`

## Requirements
- R1: A configuration write stores the receive threshold minus one in bits 13:8, the transmit threshold minus one in bits 5:0, and two stored-only DMA enable flags in bits 15 (receive) and 7 (transmit). Reading the configuration returns these fields. Bits 14 and 6 always read as zero.
- R2: A configuration write with bit 6 set empties the transmit queue, and one with bit 14 set empties the receive queue, both by the next cycle. The flush wins over a push to the same queue in that cycle.
- R3: The status word carries the size code SIZE_CODE (0 to 2) in bits 15:14, the receive level in bits 13:8 and the transmit level in bits 5:0. Bits 7:6 are zero. The queue depth is 8 << SIZE_CODE.
- R4: Both queues are first-in first-out. Bytes written to the data register appear on eng_tx_data in write order. Bytes from the engine appear on dat_rdata in arrival order.
- R5: ev_tx_rdy pulses when the remaining count is at least the transmit threshold and the free transmit space is at least the threshold.
- R6: ev_tx_drn pulses when the remaining count is non-zero, below the transmit threshold, and no larger than the free transmit space.
- R7: ev_rx_rdy pulses when the receive level and the remaining count are both at least the receive threshold.
- R8: ev_rx_drn pulses when the remaining count is non-zero, below the receive threshold, and no larger than the receive level.
- R9: Once a ready or drain event has pulsed, it stays low while its condition persists. It can fire again only after a data-register write (transmit events) or read (receive events), or a flush of that queue. Each such event lags its cause by one registered cycle.
- R10: An engine take while the transmit queue is empty raises ev_tx_udf in the next cycle, and the level stays zero.
- R11: An engine deposit while the receive queue is full raises ev_rx_overrun in the next cycle. The byte is dropped and the level stays at the full depth.
- R12: A data write to a full transmit queue is ignored. A data read from an empty receive queue is ignored. Neither changes any level or queued byte.
- R13: After reset both levels are zero, the configuration reads zero, all event outputs are low, and every ready and drain event is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Configuration readback |
| stat_rdata | output | 16 | Level and size-code status |
| dat_wr | input | 1 | Data register write (transmit push) |
| dat_wdata | input | 8 | Byte to transmit |
| dat_rd | input | 1 | Data register read (receive pop) |
| dat_rdata | output | 8 | Oldest received byte |
| eng_tx_take | input | 1 | Engine takes the oldest transmit byte |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_rx_put | input | 1 | Engine deposits a received byte |
| eng_rx_data | input | 8 | Received byte |
| remain_cnt | input | CNT_W | Bytes of the transfer software still has to move |
| ev_tx_rdy | output | 1 | Transmit ready pulse |
| ev_tx_drn | output | 1 | Transmit drain pulse |
| ev_rx_rdy | output | 1 | Receive ready pulse |
| ev_rx_drn | output | 1 | Receive drain pulse |
| ev_tx_udf | output | 1 | Transmit underflow pulse |
| ev_rx_ovr | output | 1 | Receive overrun pulse |

## Verification
The assertions assume that every strobe is sampled as a single-cycle level and that remain_cnt only changes between clock edges. The overrun property also assumes that no receive read or receive flush falls in the same cycle as the dropped deposit. The size code is taken to be at most 2, so that levels fit the 6-bit status fields. The stimulus changes inputs only on the falling edge and keeps the remaining count at zero while queues are being filled, so no event fires before the stimulus intends it. The overrun and underflow cases are driven without any competing access in the same cycle.

// File: rtl/i2cfb_pkg.sv
`timescale 1ns/1ps
package i2cfb_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned THR_W  = 6;

  // configuration word bit placement
  localparam int unsigned RX_DMA_B   = 15;
  localparam int unsigned RX_CLR_B   = 14;
  localparam int unsigned RX_THR_LSB = 8;
  localparam int unsigned TX_DMA_B   = 7;
  localparam int unsigned TX_CLR_B   = 6;
  localparam int unsigned TX_THR_LSB = 0;

  // event slots
  localparam int unsigned EV_TX_RDY = 0;
  localparam int unsigned EV_TX_DRN = 1;
  localparam int unsigned EV_RX_RDY = 2;
  localparam int unsigned EV_RX_DRN = 3;
  localparam int unsigned N_EV      = 4;

  typedef struct packed {
    logic             rx_dma;
    logic [THR_W-1:0] rx_thr_m1;
    logic             tx_dma;
    logic [THR_W-1:0] tx_thr_m1;
  } buf_cfg_t;
endpackage

// File: rtl/i2cfb_fifo.sv
`timescale 1ns/1ps
module i2cfb_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     push,
  input  logic [W-1:0]             wdata,
  input  logic                     pop,
  output logic [W-1:0]             rdata,
  output logic [$clog2(DEPTH):0]   level
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned LVL_W = PTR_W + 1;

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             full, empty, push_ok, pop_ok;

  assign full    = (lvl_q == LVL_W'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & ~empty & ~flush;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    lvl_d  = lvl_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      lvl_d  = '0;
    end else begin
      if (push_ok) wptr_d = wptr_q + PTR_W'(1);
      if (pop_ok)  rptr_d = rptr_q + PTR_W'(1);
      lvl_d = lvl_q + LVL_W'(push_ok) - LVL_W'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      lvl_q  <= lvl_d;
    end
  end

  // storage array: written only on an accepted push, no reset needed
  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wptr_q] <= wdata;
  end

  assign rdata = mem_q[rptr_q];
  assign level = lvl_q;
endmodule

// File: rtl/i2cfb_cfg.sv
`timescale 1ns/1ps
module i2cfb_cfg
  import i2cfb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [15:0] cfg_wdata,
  output buf_cfg_t    cfg_q,
  output logic        tx_flush,
  output logic        rx_flush,
  output logic [15:0] cfg_rdata
);
  buf_cfg_t cfg_d;

  always_comb begin
    cfg_d.rx_dma    = cfg_wdata[RX_DMA_B];
    cfg_d.rx_thr_m1 = cfg_wdata[RX_THR_LSB +: THR_W];
    cfg_d.tx_dma    = cfg_wdata[TX_DMA_B];
    cfg_d.tx_thr_m1 = cfg_wdata[TX_THR_LSB +: THR_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_wr) begin
      cfg_q <= cfg_d;
    end
  end

  // flush strobes act in the write cycle and are never stored
  assign tx_flush = cfg_wr & cfg_wdata[TX_CLR_B];
  assign rx_flush = cfg_wr & cfg_wdata[RX_CLR_B];

  always_comb begin
    cfg_rdata                          = '0;
    cfg_rdata[RX_DMA_B]                = cfg_q.rx_dma;
    cfg_rdata[RX_THR_LSB +: THR_W]     = cfg_q.rx_thr_m1;
    cfg_rdata[TX_DMA_B]                = cfg_q.tx_dma;
    cfg_rdata[TX_THR_LSB +: THR_W]     = cfg_q.tx_thr_m1;
  end
endmodule

// File: rtl/i2cfb_evt.sv
`timescale 1ns/1ps
module i2cfb_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic rearm,
  output logic pulse
);
  logic armed_q, armed_d, pulse_q, pulse_d, fire;

  assign fire = cond & armed_q;

  always_comb begin
    pulse_d = fire;
    armed_d = rearm | (armed_q & ~fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/i2c_thresh_buf.sv
`timescale 1ns/1ps
module i2c_thresh_buf
  import i2cfb_pkg::*;
#(
  parameter int unsigned SIZE_CODE = 1,
  parameter int unsigned CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [15:0]      cfg_wdata,
  output logic [15:0]      cfg_rdata,
  output logic [15:0]      stat_rdata,
  input  logic             dat_wr,
  input  logic [7:0]       dat_wdata,
  input  logic             dat_rd,
  output logic [7:0]       dat_rdata,
  input  logic             eng_tx_take,
  output logic [7:0]       eng_tx_data,
  input  logic             eng_rx_put,
  input  logic [7:0]       eng_rx_data,
  input  logic [CNT_W-1:0] remain_cnt,
  output logic             ev_tx_rdy,
  output logic             ev_tx_drn,
  output logic             ev_rx_rdy,
  output logic             ev_rx_drn,
  output logic             ev_tx_udf,
  output logic             ev_rx_ovr
);
  localparam int unsigned DEPTH = 8 << SIZE_CODE;
  localparam int unsigned LVL_W = $clog2(DEPTH) + 1;
  localparam int unsigned CMP_W = ((CNT_W > THR_W + 1) ? CNT_W : THR_W + 1) + 1;

  // configuration
  buf_cfg_t cfg_q;
  logic     tx_flush, rx_flush;

  i2cfb_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_q     (cfg_q),
    .tx_flush  (tx_flush),
    .rx_flush  (rx_flush),
    .cfg_rdata (cfg_rdata)
  );

  // byte queues
  logic [LVL_W-1:0] tx_lvl, rx_lvl;

  i2cfb_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (tx_flush),
    .push  (dat_wr),
    .wdata (dat_wdata),
    .pop   (eng_tx_take),
    .rdata (eng_tx_data),
    .level (tx_lvl)
  );

  i2cfb_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (rx_flush),
    .push  (eng_rx_put),
    .wdata (eng_rx_data),
    .pop   (dat_rd),
    .rdata (dat_rdata),
    .level (rx_lvl)
  );

  logic tx_empty, rx_full;
  assign tx_empty = (tx_lvl == '0);
  assign rx_full  = (rx_lvl == LVL_W'(DEPTH));

  // compare operands, all widened to one common width
  logic [CMP_W-1:0] rem_w, tx_thr_w, rx_thr_w, tx_free_w, rx_lvl_w;
  logic             rem_nz;

  assign rem_w     = CMP_W'(remain_cnt);
  assign tx_thr_w  = CMP_W'(cfg_q.tx_thr_m1) + CMP_W'(1);
  assign rx_thr_w  = CMP_W'(cfg_q.rx_thr_m1) + CMP_W'(1);
  assign tx_free_w = CMP_W'(DEPTH) - CMP_W'(tx_lvl);
  assign rx_lvl_w  = CMP_W'(rx_lvl);
  assign rem_nz    = (rem_w != '0);

  logic [N_EV-1:0] ev_cond, ev_rearm, ev_pulse;

  always_comb begin
    ev_cond[EV_TX_RDY] = (rem_w >= tx_thr_w) && (tx_free_w >= tx_thr_w);
    ev_cond[EV_TX_DRN] = rem_nz && (rem_w < tx_thr_w) && (tx_free_w >= rem_w);
    ev_cond[EV_RX_RDY] = (rx_lvl_w >= rx_thr_w) && (rem_w >= rx_thr_w);
    ev_cond[EV_RX_DRN] = rem_nz && (rem_w < rx_thr_w) && (rx_lvl_w >= rem_w);
    ev_rearm[EV_TX_RDY] = dat_wr | tx_flush;
    ev_rearm[EV_TX_DRN] = dat_wr | tx_flush;
    ev_rearm[EV_RX_RDY] = dat_rd | rx_flush;
    ev_rearm[EV_RX_DRN] = dat_rd | rx_flush;
  end

  for (genvar g = 0; g < N_EV; g++) begin : g_ev
    i2cfb_evt u_evt (
      .clk   (clk),
      .rst_n (rst_n),
      .cond  (ev_cond[g]),
      .rearm (ev_rearm[g]),
      .pulse (ev_pulse[g])
    );
  end

  assign ev_tx_rdy = ev_pulse[EV_TX_RDY];
  assign ev_tx_drn = ev_pulse[EV_TX_DRN];
  assign ev_rx_rdy = ev_pulse[EV_RX_RDY];
  assign ev_rx_drn = ev_pulse[EV_RX_DRN];

  // error pulses
  logic udf_d, udf_q, ovr_d, ovr_q;
  assign udf_d = eng_tx_take & tx_empty;
  assign ovr_d = eng_rx_put & rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      udf_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      udf_q <= udf_d;
      ovr_q <= ovr_d;
    end
  end

  assign ev_tx_udf = udf_q;
  assign ev_rx_ovr = ovr_q;

  assign stat_rdata = {2'(SIZE_CODE), 6'(rx_lvl), 2'b00, 6'(tx_lvl)};
endmodule

// File: rtl/i2c_thresh_buf_chk.sv
`timescale 1ns/1ps
module i2c_thresh_buf_chk #(
  parameter int unsigned SIZE_CODE = 1,
  parameter int unsigned CNT_W     = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [15:0]      cfg_wdata,
  input logic [15:0]      cfg_rdata,
  input logic [15:0]      stat_rdata,
  input logic             dat_wr,
  input logic             dat_rd,
  input logic             eng_tx_take,
  input logic             eng_rx_put,
  input logic [CNT_W-1:0] remain_cnt,
  input logic             ev_tx_rdy,
  input logic             ev_tx_drn,
  input logic             ev_rx_rdy,
  input logic             ev_rx_drn,
  input logic             ev_tx_udf,
  input logic             ev_rx_ovr
);
  localparam int unsigned DEPTH = 8 << SIZE_CODE;
  localparam logic [6:0]  DEPTH7 = 7'(DEPTH);

  logic [CNT_W:0] rem_x, txthr_x, rxthr_x, rxlvl_x;
  assign rem_x   = (CNT_W+1)'(remain_cnt);
  assign txthr_x = (CNT_W+1)'(cfg_rdata[5:0]) + (CNT_W+1)'(1);
  assign rxthr_x = (CNT_W+1)'(cfg_rdata[13:8]) + (CNT_W+1)'(1);
  assign rxlvl_x = (CNT_W+1)'(stat_rdata[13:8]);

  assert_flush_tx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_wdata[6] |=> stat_rdata[5:0] == 6'd0);

  assert_flush_rx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_wdata[14] |=> stat_rdata[13:8] == 6'd0);

  assert_status_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata[15:14] == 2'(SIZE_CODE) && stat_rdata[7:6] == 2'b00 &&
    {1'b0, stat_rdata[5:0]} <= DEPTH7 && {1'b0, stat_rdata[13:8]} <= DEPTH7);

  assert_tx_rdy_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_rdy |-> $past(rem_x) >= $past(txthr_x));

  assert_tx_drn_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_drn |-> ($past(rem_x) != '0) && ($past(rem_x) < $past(txthr_x)));

  assert_rx_rdy_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_rdy |-> $past(rxlvl_x) >= $past(rxthr_x));

  assert_rx_drn_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_drn |-> ($past(rem_x) != '0) && ($past(rxlvl_x) >= $past(rem_x)));

  assert_quiet_after_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_rdy && !$past(dat_wr) && !$past(cfg_wr && cfg_wdata[6]) |=> !ev_tx_rdy);

  assert_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_tx_take && stat_rdata[5:0] == 6'd0 |=> ev_tx_udf);

  assert_overrun_R11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rx_put && {1'b0, stat_rdata[13:8]} == DEPTH7 && !dat_rd && !(cfg_wr && cfg_wdata[14])
    |=> ev_rx_ovr && {1'b0, stat_rdata[13:8]} == DEPTH7);
endmodule

bind i2c_thresh_buf i2c_thresh_buf_chk #(.SIZE_CODE(SIZE_CODE), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr      (cfg_wr),
  .cfg_wdata   (cfg_wdata),
  .cfg_rdata   (cfg_rdata),
  .stat_rdata  (stat_rdata),
  .dat_wr      (dat_wr),
  .dat_rd      (dat_rd),
  .eng_tx_take (eng_tx_take),
  .eng_rx_put  (eng_rx_put),
  .remain_cnt  (remain_cnt),
  .ev_tx_rdy   (ev_tx_rdy),
  .ev_tx_drn   (ev_tx_drn),
  .ev_rx_rdy   (ev_rx_rdy),
  .ev_rx_drn   (ev_rx_drn),
  .ev_tx_udf   (ev_tx_udf),
  .ev_rx_ovr   (ev_rx_ovr)
);

// File: tb/test_i2c_thresh_buf.sv
`timescale 1ns/1ps
module test_i2c_thresh_buf;
  localparam int unsigned SIZE_CODE = 1;
  localparam int unsigned CNT_W     = 16;

  logic        clk, rst_n;
  logic        cfg_wr, dat_wr, dat_rd, eng_tx_take, eng_rx_put;
  logic [15:0] cfg_wdata, cfg_rdata, stat_rdata, remain_cnt;
  logic [7:0]  dat_wdata, dat_rdata, eng_tx_data, eng_rx_data;
  logic        ev_tx_rdy, ev_tx_drn, ev_rx_rdy, ev_rx_drn, ev_tx_udf, ev_rx_ovr;

  i2c_thresh_buf #(.SIZE_CODE(SIZE_CODE), .CNT_W(CNT_W)) i_i2c_thresh_buf (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .stat_rdata(stat_rdata),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rd(dat_rd), .dat_rdata(dat_rdata),
    .eng_tx_take(eng_tx_take), .eng_tx_data(eng_tx_data),
    .eng_rx_put(eng_rx_put), .eng_rx_data(eng_rx_data),
    .remain_cnt(remain_cnt),
    .ev_tx_rdy(ev_tx_rdy), .ev_tx_drn(ev_tx_drn),
    .ev_rx_rdy(ev_rx_rdy), .ev_rx_drn(ev_rx_drn),
    .ev_tx_udf(ev_tx_udf), .ev_rx_ovr(ev_rx_ovr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // vector: tx thr-1, rx thr-1, tx fill, rx fill, remaining, expected {txr,txd,rxr,rxd}
  typedef struct packed {
    logic [5:0]  tf;
    logic [5:0]  rf;
    logic [7:0]  txn;
    logic [7:0]  rxn;
    logic [15:0] rem;
    logic [3:0]  exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{6'd3,  6'd3,  8'd0,  8'd4,  16'd8,  4'b1010},
    '{6'd3,  6'd3,  8'd14, 8'd3,  16'd8,  4'b0000},
    '{6'd7,  6'd7,  8'd10, 8'd5,  16'd5,  4'b0101},
    '{6'd7,  6'd7,  8'd12, 8'd4,  16'd5,  4'b0000},
    '{6'd15, 6'd15, 8'd0,  8'd16, 16'd16, 4'b1010},
    '{6'd0,  6'd1,  8'd15, 8'd1,  16'd1,  4'b1001},
    '{6'd31, 6'd31, 8'd0,  8'd16, 16'd40, 4'b0000},
    '{6'd3,  6'd3,  8'd16, 8'd0,  16'd2,  4'b0000}
  };

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic cfg_write(input logic [15:0] v);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic push_tx(input logic [7:0] b);
    dat_wr = 1'b1; dat_wdata = b;
    @(negedge clk);
    dat_wr = 1'b0;
  endtask

  task automatic take_tx;
    eng_tx_take = 1'b1;
    @(negedge clk);
    eng_tx_take = 1'b0;
  endtask

  task automatic put_rx(input logic [7:0] b);
    eng_rx_put = 1'b1; eng_rx_data = b;
    @(negedge clk);
    eng_rx_put = 1'b0;
  endtask

  task automatic read_rx;
    dat_rd = 1'b1;
    @(negedge clk);
    dat_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; dat_wr = 1'b0; dat_wdata = '0;
    dat_rd = 1'b0; eng_tx_take = 1'b0; eng_rx_put = 1'b0; eng_rx_data = '0; remain_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    check("R13 cfg", cfg_rdata, 16'h0000);
    check("R13 status", stat_rdata, 16'h4000);
    check("R13 events", 16'({ev_tx_rdy, ev_tx_drn, ev_rx_rdy, ev_rx_drn, ev_tx_udf, ev_rx_ovr}), 16'h0);

    // table walk: R5 R6 R7 R8 and R3 levels
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      remain_cnt = '0;
      cfg_write({1'b0, 1'b1, v.rf, 1'b0, 1'b1, v.tf});
      for (int k = 0; k < int'(v.txn); k++) push_tx(8'(k));
      for (int k = 0; k < int'(v.rxn); k++) put_rx(8'(k + 64));
      remain_cnt = v.rem;
      @(negedge clk);
      check("R5 tx ready", 16'(ev_tx_rdy), 16'(v.exp[3]));
      check("R6 tx drain", 16'(ev_tx_drn), 16'(v.exp[2]));
      check("R7 rx ready", 16'(ev_rx_rdy), 16'(v.exp[1]));
      check("R8 rx drain", 16'(ev_rx_drn), 16'(v.exp[0]));
      check("R3 levels", stat_rdata, {2'(SIZE_CODE), v.rxn[5:0], 2'b00, v.txn[5:0]});
      remain_cnt = '0;
      @(negedge clk);
    end

    // R1 configuration readback
    cfg_write(16'hFFFF);
    check("R1 all ones", cfg_rdata, 16'hBFBF);
    cfg_write(16'h8305);
    check("R1 fields", cfg_rdata, 16'h8305);

    // R4 ordering
    cfg_write(16'h4040);
    push_tx(8'hA1); push_tx(8'hA2); push_tx(8'hA3);
    check("R4 tx head 1", 16'(eng_tx_data), 16'h00A1);
    take_tx();
    check("R4 tx head 2", 16'(eng_tx_data), 16'h00A2);
    take_tx();
    check("R4 tx head 3", 16'(eng_tx_data), 16'h00A3);
    check("R4 tx level", 16'(stat_rdata[5:0]), 16'd1);
    take_tx();
    put_rx(8'h5C); put_rx(8'h6D);
    check("R4 rx head 1", 16'(dat_rdata), 16'h005C);
    read_rx();
    check("R4 rx head 2", 16'(dat_rdata), 16'h006D);
    read_rx();
    check("R4 rx level", 16'(stat_rdata[13:8]), 16'd0);

    // R12 full write and empty read ignored
    for (int k = 0; k < 16; k++) push_tx(8'(k + 16));
    push_tx(8'h99);
    check("R12 tx level full", 16'(stat_rdata[5:0]), 16'd16);
    check("R12 tx head kept", 16'(eng_tx_data), 16'h0010);
    for (int k = 0; k < 15; k++) take_tx();
    check("R12 tx last byte", 16'(eng_tx_data), 16'h001F);
    take_tx();
    check("R12 tx drained", 16'(stat_rdata[5:0]), 16'd0);
    read_rx();
    check("R12 rx empty read", 16'(stat_rdata[13:8]), 16'd0);
    put_rx(8'h77);
    check("R12 rx after empty read", 16'(dat_rdata), 16'h0077);
    read_rx();

    // R10 underflow
    take_tx();
    check("R10 underflow pulse", 16'(ev_tx_udf), 16'd1);
    check("R10 level held", 16'(stat_rdata[5:0]), 16'd0);
    @(negedge clk);
    check("R10 pulse ends", 16'(ev_tx_udf), 16'd0);

    // R11 overrun
    for (int k = 0; k < 16; k++) put_rx(8'(k + 32));
    put_rx(8'hEE);
    check("R11 overrun pulse", 16'(ev_rx_ovr), 16'd1);
    check("R11 level held", 16'(stat_rdata[13:8]), 16'd16);
    check("R11 head kept", 16'(dat_rdata), 16'h0020);

    // R2 flushes
    push_tx(8'h01); push_tx(8'h02); push_tx(8'h03);
    cfg_write(16'h0040);
    check("R2 tx flushed", 16'(stat_rdata[5:0]), 16'd0);
    check("R2 rx untouched", 16'(stat_rdata[13:8]), 16'd16);
    cfg_write(16'h4000);
    check("R2 rx flushed", 16'(stat_rdata[13:8]), 16'd0);
    cfg_wr = 1'b1; cfg_wdata = 16'h0040; dat_wr = 1'b1; dat_wdata = 8'h42;
    @(negedge clk);
    cfg_wr = 1'b0; dat_wr = 1'b0;
    check("R2 flush beats push", 16'(stat_rdata[5:0]), 16'd0);

    // R9 re-arm on transmit side
    cfg_write(16'h4343);
    remain_cnt = 16'd8;
    @(negedge clk);
    check("R9 tx first fire", 16'(ev_tx_rdy), 16'd1);
    @(negedge clk);
    check("R9 tx quiet 1", 16'(ev_tx_rdy), 16'd0);
    @(negedge clk);
    check("R9 tx quiet 2", 16'(ev_tx_rdy), 16'd0);
    push_tx(8'h55);
    check("R9 tx lag", 16'(ev_tx_rdy), 16'd0);
    @(negedge clk);
    check("R9 tx refire", 16'(ev_tx_rdy), 16'd1);

    // R9 re-arm on receive side
    remain_cnt = '0;
    for (int k = 0; k < 5; k++) put_rx(8'(k));
    remain_cnt = 16'd8;
    @(negedge clk);
    check("R9 rx first fire", 16'(ev_rx_rdy), 16'd1);
    @(negedge clk);
    check("R9 rx quiet", 16'(ev_rx_rdy), 16'd0);
    read_rx();
    check("R9 rx lag", 16'(ev_rx_rdy), 16'd0);
    @(negedge clk);
    check("R9 rx refire", 16'(ev_rx_rdy), 16'd1);
    remain_cnt = '0;
    @(negedge clk);

    done = 1'b1;
    report();
    $finish;
  end
endmodule